// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of an 8 KB packet memory that is divided into 256-byte pages. A host drives single-cycle commands. It can reserve a run of pages for a new packet, hand back the pages of a packet, drop the oldest received packet, place a packet number on the transmit queue, or wipe all state. The block itself holds no packet data. It only decides which pages each packet occupies, and it names each packet by the index of its first page.

A page request carries a size code equal to the number of pages minus one. A requester usually derives the code from the frame length as ((length with bit 0 cleared) + 6) >> 8. Codes above 7 count as oversize. A successful request returns the packet number and raises an interrupt flag, which stays set until the host acknowledges it. A failed request returns a failure bit instead. The receive datapath pushes the numbers of arriving packets into a queue, which the host reads and releases in order. The transmit side pops the queue that the host fills. Free space is reported in units of 2048 bytes.

Every accepted command makes the block busy for exactly one cycle. Its effects are visible on the cycle after that.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, busy, alloc_int, res_fail and res_pnum are 0, both queues are empty, and mem_free reads 4 because all 32 pages are free.
- R2: A command is accepted when cmd_valid is high at a clock edge while busy is low. busy is then high for exactly the next cycle, and the results are visible once busy falls. A command presented while busy is high is ignored.
- R3: Op code 1 (ALLOC) with cmd_arg = c, where c is 0..7, reserves c+1 contiguous free pages at the lowest starting page where they fit. res_pnum returns that starting page, and res_fail returns 0.
- R4: A successful ALLOC sets alloc_int. alloc_int stays set until int_ack is high at a clock edge, and a failed ALLOC does not set it.
- R5: An ALLOC with a code above 7, or with no free run long enough, returns res_fail = 1 and res_pnum = 0, and leaves every page unchanged.
- R6: Op code 4 (FREE) with cmd_arg equal to the starting page of an allocated packet frees all pages of that packet. Any other cmd_arg has no effect.
- R7: mem_free equals the number of free pages divided by 8, rounded down.
- R8: A pulse on rx_push appends rx_pnum to the receive queue. rx_empty and rx_head show the oldest entry, and a push to a queue that already holds 32 entries is dropped.
- R9: Op code 3 (RELEASE) removes the head of the receive queue and frees that packet's pages if the head number is an allocated packet. On an empty queue it has no effect.
- R10: Op code 5 (ENQUEUE) appends cmd_arg[4:0] to the transmit queue. A pulse on tx_pop removes the oldest entry, and tx_empty and tx_head show the oldest entry.
- R11: Op code 2 (RESET) frees every page, empties both queues, and clears alloc_int, res_fail and res_pnum. Op codes 0, 6 and 7 do nothing beyond the busy cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 8 | Size code or packet number |
| busy | output | 1 | A command is executing |
| int_ack | input | 1 | Clears alloc_int |
| alloc_int | output | 1 | A successful allocation is pending acknowledge |
| res_pnum | output | 5 | Packet number from the last ALLOC |
| res_fail | output | 1 | The last ALLOC failed |
| rx_push | input | 1 | Append rx_pnum to the receive queue |
| rx_pnum | input | 5 | Received packet number |
| rx_empty | output | 1 | Receive queue holds no entry |
| rx_head | output | 5 | Oldest received packet number |
| tx_pop | input | 1 | Remove the head of the transmit queue |
| tx_empty | output | 1 | Transmit queue holds no entry |
| tx_head | output | 5 | Oldest queued transmit packet number |
| mem_free | output | 8 | Free memory in 2048-byte units |

## Verification
The bench covers several cases where a wrong design would still look plausible. Freed holes must be reused first-fit: a design that allocates past the last used page instead would return a higher packet number than the model. A FREE aimed at a page in the middle of a packet must not be honoured, or a later allocation would land inside a packet that is still live. An oversize code and a full memory must fail without touching pages, and must leave the interrupt flag alone. A RESET presented while the block is busy must be dropped, or the pages just allocated would vanish. A long random phase then mixes allocations, frees, queue pushes, releases and pops against a bench model, so that any drift in occupancy shows up as a wrong packet number.

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
  parameter int MEM_BYTES  = 8192,
  parameter int PAGE_BYTES = 256,
  parameter int UNIT_BYTES = 2048,
  parameter int CODE_MAX   = 7,
  parameter int ARG_W      = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmd_valid,
  input  logic [2:0]                            cmd_op,
  input  logic [ARG_W-1:0]                      cmd_arg,
  output logic                                  busy,
  input  logic                                  int_ack,
  output logic                                  alloc_int,
  output logic [$clog2(MEM_BYTES/PAGE_BYTES)-1:0] res_pnum,
  output logic                                  res_fail,
  input  logic                                  rx_push,
  input  logic [$clog2(MEM_BYTES/PAGE_BYTES)-1:0] rx_pnum,
  output logic                                  rx_empty,
  output logic [$clog2(MEM_BYTES/PAGE_BYTES)-1:0] rx_head,
  input  logic                                  tx_pop,
  output logic                                  tx_empty,
  output logic [$clog2(MEM_BYTES/PAGE_BYTES)-1:0] tx_head,
  output logic [7:0]                            mem_free
);
  localparam int NPAGES     = MEM_BYTES / PAGE_BYTES;
  localparam int PW         = $clog2(NPAGES);
  localparam int CW         = $clog2(NPAGES + 1);
  localparam int LW         = $clog2(CODE_MAX + 1);
  localparam int UNIT_PAGES = UNIT_BYTES / PAGE_BYTES;

  localparam logic [2:0] OP_ALLOC = 3'd1;
  localparam logic [2:0] OP_RESET = 3'd2;
  localparam logic [2:0] OP_REL   = 3'd3;
  localparam logic [2:0] OP_FREE  = 3'd4;
  localparam logic [2:0] OP_ENQ   = 3'd5;

  logic [NPAGES-1:0] used, starts;
  logic [LW-1:0]     len_mem [NPAGES];
  logic              pend;
  logic [2:0]        pend_op;
  logic [ARG_W-1:0]  pend_arg;

  logic [PW-1:0] rx_mem [NPAGES];
  logic [PW-1:0] tx_mem [NPAGES];
  logic [PW-1:0] rx_rd, rx_wr, tx_rd, tx_wr;
  logic [CW-1:0] rx_cnt, tx_cnt, free_cnt;

  logic [NPAGES-1:0] run_mask, alloc_mask, free_mask;
  logic              fit_ok;
  logic [PW-1:0]     fit_pos, tgt;
  logic              tgt_ok;

  assign busy     = pend;
  assign rx_empty = (rx_cnt == '0);
  assign tx_empty = (tx_cnt == '0);
  assign rx_head  = rx_mem[rx_rd];
  assign tx_head  = tx_mem[tx_rd];
  assign mem_free = 8'(free_cnt / CW'(UNIT_PAGES));

  always_comb begin
    for (int i = 0; i < NPAGES; i++) run_mask[i] = (i <= int'(pend_arg));
    fit_ok  = 1'b0;
    fit_pos = '0;
    for (int s = NPAGES - 1; s >= 0; s--) begin
      if (int'(pend_arg) <= CODE_MAX && s + int'(pend_arg) < NPAGES &&
          ((used >> s) & run_mask) == '0) begin
        fit_ok  = 1'b1;
        fit_pos = PW'(s);
      end
    end
  end
  assign alloc_mask = run_mask << fit_pos;

  assign tgt = (pend_op == OP_REL) ? rx_head : pend_arg[PW-1:0];
  assign tgt_ok = (pend_op == OP_REL) ? (!rx_empty && starts[tgt])
                                      : (int'(pend_arg) < NPAGES && starts[tgt]);

  always_comb begin
    for (int i = 0; i < NPAGES; i++)
      free_mask[i] = (i >= int'(tgt)) && (i <= int'(tgt) + int'(len_mem[tgt]));
    free_cnt = '0;
    for (int i = 0; i < NPAGES; i++)
      if (!used[i]) free_cnt = free_cnt + CW'(1);
  end

  logic do_alloc, alloc_ok, do_free, do_rst, rx_pop_e, rx_push_e, tx_push_e, tx_pop_e;
  assign do_alloc  = pend && pend_op == OP_ALLOC;
  assign alloc_ok  = do_alloc && fit_ok;
  assign do_free   = pend && (pend_op == OP_FREE || pend_op == OP_REL) && tgt_ok;
  assign do_rst    = pend && pend_op == OP_RESET;
  assign rx_pop_e  = pend && pend_op == OP_REL && !rx_empty;
  assign rx_push_e = rx_push && rx_cnt != CW'(NPAGES);
  assign tx_push_e = pend && pend_op == OP_ENQ && tx_cnt != CW'(NPAGES);
  assign tx_pop_e  = tx_pop && !tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_op <= '0; pend_arg <= '0;
      used <= '0; starts <= '0;
      alloc_int <= 1'b0; res_fail <= 1'b0; res_pnum <= '0;
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
    end else begin
      pend <= cmd_valid && !pend;
      if (cmd_valid && !pend) begin
        pend_op  <= cmd_op;
        pend_arg <= cmd_arg;
      end
      if (do_rst) begin
        used <= '0; starts <= '0;
        alloc_int <= 1'b0; res_fail <= 1'b0; res_pnum <= '0;
        rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
        tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
      end else begin
        if (alloc_ok) begin
          used <= used | alloc_mask;
          starts[fit_pos] <= 1'b1;
        end
        if (do_free) begin
          used <= used & ~free_mask;
          starts[tgt] <= 1'b0;
        end
        if (do_alloc) begin
          res_fail <= !fit_ok;
          res_pnum <= fit_ok ? fit_pos : '0;
        end
        if (alloc_ok) alloc_int <= 1'b1;
        else if (int_ack) alloc_int <= 1'b0;
        if (rx_push_e) rx_wr <= rx_wr + PW'(1);
        if (rx_pop_e)  rx_rd <= rx_rd + PW'(1);
        rx_cnt <= rx_cnt + CW'(rx_push_e) - CW'(rx_pop_e);
        if (tx_push_e) tx_wr <= tx_wr + PW'(1);
        if (tx_pop_e)  tx_rd <= tx_rd + PW'(1);
        tx_cnt <= tx_cnt + CW'(tx_push_e) - CW'(tx_pop_e);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_ok)  len_mem[fit_pos] <= LW'(pend_arg);
    if (rx_push_e) rx_mem[rx_wr] <= rx_pnum;
    if (tx_push_e) tx_mem[tx_wr] <= pend_arg[PW-1:0];
  end

  assert_busy_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_int_after_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_int) |-> ($past(busy) && !res_fail));
  assert_fail_keeps_pages_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_fail) |-> $stable(used));
  assert_idle_pages_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(used));
  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend_op == OP_RESET) |=> (rx_empty && tx_empty && !alloc_int && used == '0));
endmodule

// File: tb/pkt_page_alloc_bench.sv
module pkt_page_alloc_bench;
  localparam int NP = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, int_ack = 1'b0, rx_push = 1'b0, tx_pop = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_arg = '0;
  logic [4:0] rx_pnum = '0;
  logic busy, alloc_int, res_fail, rx_empty, tx_empty;
  logic [4:0] res_pnum, rx_head, tx_head;
  logic [7:0] mem_free;

  always #2 clk = ~clk;

  pkt_page_alloc u_pkt_page_alloc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .busy(busy), .int_ack(int_ack), .alloc_int(alloc_int), .res_pnum(res_pnum),
    .res_fail(res_fail), .rx_push(rx_push), .rx_pnum(rx_pnum), .rx_empty(rx_empty),
    .rx_head(rx_head), .tx_pop(tx_pop), .tx_empty(tx_empty), .tx_head(tx_head),
    .mem_free(mem_free));

  int checks = 0, errors = 0;
  bit [NP-1:0] m_used, m_start;
  int m_len [NP];
  int rxq[$], txq[$];
  bit m_int, m_fail;
  int m_pnum;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int first_fit(int code);
    if (code > 7) return -1;
    for (int s = 0; s + code < NP; s++) begin
      bit ok = 1'b1;
      for (int k = 0; k <= code; k++) if (m_used[s+k]) ok = 1'b0;
      if (ok) return s;
    end
    return -1;
  endfunction

  function automatic int free_units();
    int n = 0;
    for (int i = 0; i < NP; i++) if (!m_used[i]) n++;
    return n / 8;
  endfunction

  function automatic void m_free(int p);
    if (p >= 0 && p < NP && m_start[p]) begin
      for (int k = 0; k <= m_len[p]; k++) m_used[p+k] = 1'b0;
      m_start[p] = 1'b0;
    end
  endfunction

  task automatic check_all(string req);
    chk(req, busy, 0, "busy");
    chk(req, alloc_int, m_int, "alloc_int");
    chk(req, res_fail, m_fail, "res_fail");
    chk(req, res_pnum, m_pnum, "res_pnum");
    chk(req, mem_free, free_units(), "mem_free");
    chk(req, rx_empty, rxq.size() == 0, "rx_empty");
    if (rxq.size() > 0) chk(req, rx_head, rxq[0], "rx_head");
    chk(req, tx_empty, txq.size() == 0, "tx_empty");
    if (txq.size() > 0) chk(req, tx_head, txq[0], "tx_head");
  endtask

  task automatic model_cmd(int op, int arg);
    case (op)
      1: begin
        int s = first_fit(arg);
        if (s >= 0) begin
          for (int k = 0; k <= arg; k++) m_used[s+k] = 1'b1;
          m_start[s] = 1'b1; m_len[s] = arg;
          m_int = 1'b1; m_fail = 1'b0; m_pnum = s;
        end else begin
          m_fail = 1'b1; m_pnum = 0;
        end
      end
      2: begin
        m_used = '0; m_start = '0; rxq.delete(); txq.delete();
        m_int = 1'b0; m_fail = 1'b0; m_pnum = 0;
      end
      3: if (rxq.size() > 0) begin
        int p = rxq.pop_front();
        m_free(p);
      end
      4: m_free(arg);
      5: if (txq.size() < NP) txq.push_back(arg % NP);
      default: ;
    endcase
  endtask

  task automatic cmd(int op, int arg, string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_arg = 8'(arg);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2", busy, 1, "busy after accept");
    model_cmd(op, arg);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic push_rx(int p);
    @(negedge clk); rx_push = 1'b1; rx_pnum = 5'(p);
    @(negedge clk); rx_push = 1'b0;
    if (rxq.size() < NP) rxq.push_back(p);
    check_all("R8");
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
    if (txq.size() > 0) void'(txq.pop_front());
    check_all("R10");
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    m_int = 1'b0;
    check_all("R4");
  endtask

  function automatic int pick_start();
    int off = $urandom_range(0, NP - 1);
    for (int i = 0; i < NP; i++) if (m_start[(off + i) % NP]) return (off + i) % NP;
    return off;
  endfunction

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    m_used = '0; m_start = '0; m_int = 0; m_fail = 0; m_pnum = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    chk("R1", mem_free, 4, "mem_free at reset");

    cmd(1, 0, "R3");
    chk("R3", res_pnum, 0, "first packet");
    chk("R4", alloc_int, 1, "int set");
    ack();
    cmd(1, 7, "R3");
    cmd(1, 3, "R3");
    chk("R7", mem_free, 2, "19 free pages");
    cmd(4, 1, "R6");
    cmd(1, 2, "R3");
    chk("R3", res_pnum, 1, "reuse hole");
    cmd(4, 2, "R6");
    cmd(4, 40, "R6");
    cmd(1, 0, "R3");
    chk("R6", res_pnum, 4, "mid-packet free ignored");
    ack();
    cmd(1, 8, "R5");
    chk("R5", res_fail, 1, "oversize code");
    chk("R4", alloc_int, 0, "no int on fail");
    repeat (4) cmd(1, 7, "R5");
    chk("R5", res_fail, 1, "memory exhausted");

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_arg = 8'd0;
    @(negedge clk);
    cmd_op = 3'd2;
    chk("R2", busy, 1, "busy");
    model_cmd(4, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2", busy, 0, "command during busy ignored");
    @(negedge clk);
    check_all("R2");

    cmd(3, 0, "R9");
    push_rx(1); push_rx(9); push_rx(0);
    cmd(3, 0, "R9");
    cmd(3, 0, "R9");
    cmd(3, 0, "R9");
    cmd(3, 0, "R9");
    cmd(5, 9, "R10"); cmd(5, 3, "R10"); cmd(5, 40, "R10");
    pop_tx();
    push_rx(4);
    cmd(2, 0, "R11");
    chk("R11", mem_free, 4, "all free after reset");
    cmd(6, 0, "R11");

    for (int it = 0; it < 500; it++) begin
      int r = $urandom_range(0, 99);
      if (r < 35) cmd(1, $urandom_range(0, 8), "R3");
      else if (r < 55) cmd(4, ($urandom_range(0, 1) != 0) ? pick_start() : $urandom_range(0, 40), "R6");
      else if (r < 65) push_rx(pick_start());
      else if (r < 72) cmd(3, 0, "R9");
      else if (r < 82) cmd(5, $urandom_range(0, 255), "R10");
      else if (r < 90) pop_tx();
      else if (r < 97) ack();
      else cmd(2, 0, "R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule